// File: doc/BRIEF.md
# Prescaled Multi-Channel Period Capture

This block measures the period, and so the frequency, of several independent pulse inputs without any per-event help from a processor. Each channel brings its pin into the clock domain through a short synchronizer chain and detects rising and falling transitions. A per-channel configuration bit picks which of the two transition kinds is counted. A decimating counter turns every N counted transitions into one terminal event, with N programmable per channel from 25 to 30. A per-channel timebase counter advances on every clock. On each terminal event the counter value is copied into that channel's result word, and the counter starts again from zero in the same cycle. The stored value therefore spans N input periods.

A host reads result words whenever it chooses through a simple registered read port. Reading a channel clears its fresh-data flag. No capture waits for an acknowledgement and none raises an interrupt. A capture that lands in the same cycle as a read still leaves the flag set. Writing a channel's configuration restarts that channel's decimation and timebase. The next result is flagged as covering only part of an interval.

Top module: `period_capture_top`

## Requirements
- R1: After synchronous reset, a read of any channel returns an all-zero result word.
- R2: Channels are independent: transitions and configuration writes on one channel never change another channel's result word or flags.
- R3: The configuration edge bit selects the counted transition: 0 counts rising edges of the pin and 1 counts falling edges. The other transition kind is ignored. After reset every channel counts rising edges.
- R4: One capture occurs per N counted transitions, where N is the channel's ratio. A written ratio below 25 acts as 25 and one above 30 acts as 30. The reset ratio is 25.
- R5: The timebase increments once per clock and is zeroed in the capture cycle. The captured count (bits CNT_W-1:0 of the word) therefore equals the number of clock cycles between two consecutive captures minus one.
- R6: The timebase saturates at 2^CNT_W-1 instead of wrapping. The overflow bit (bit CNT_W+1) of the word is 1 exactly when the captured count is saturated, and it keeps that value until the next capture.
- R7: The valid bit (bit CNT_W+2) is set by every capture and cleared by a read of that channel. A capture in the same cycle as a read leaves it set.
- R8: A read request on rd_en with rd_ch returns the whole word of that channel on rd_data, with rd_ack high, one cycle later. The word is a snapshot taken in a single cycle, and rd_data holds its value while no read is requested.
- R9: A configuration write zeroes that channel's decimation count and timebase. The first capture after reset or after a configuration write has its partial bit (bit CNT_W) set, and later captures have it clear.
- R10: A pin change passes through a two-stage synchronizer. A transition that completes a decimation group on a pin driven just before rising clock edge E0 updates the result word at edge E2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | NCH | Asynchronous pulse pins, one per channel |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the configuration write |
| cfg_ratio | input | 5 | Requested decimation ratio, clamped to 25..30 |
| cfg_fall | input | 1 | Counted transition: 0 rising, 1 falling |
| rd_en | input | 1 | Read request |
| rd_ch | input | CH_W | Channel to read |
| rd_data | output | CNT_W+3 | {valid, overflow, partial, count} of the read channel |
| rd_ack | output | 1 | High for one cycle when rd_data holds a requested word |

## Verification
On every cycle the assertions check the following:
- the decimation count stays below the ratio and steps only on counted transitions;
- the timebase increments, saturates, and restarts on capture or configuration;
- the result word changes only at a capture;
- the valid flag follows capture and read;
- the configured ratio stays inside 25..30;
- the read port acknowledges and holds its data.

The end-to-end relationships are shown only by the bench's scenarios:
- captured counts that match the cycle distance between the N-th selected transitions;
- rising versus falling selection on pulses with uneven high and low times;
- clamping of out-of-range ratios;
- the partial flag after reconfiguration;
- the saturated overflow result and its clearing;
- the exact capture latency against a coincident read.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    // width of the programmable decimation ratio field
    localparam int RATIO_W = 5;

    // number of flag bits stacked above the captured count
    localparam int FLAG_W = 3;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    // status carried next to every captured count
    typedef struct packed {
        logic valid;
        logic ovf;
        logic partial;
    } cap_flags_t;

    // bring a requested ratio into the supported window
    function automatic logic [RATIO_W-1:0] clamp_ratio(
        input logic [RATIO_W-1:0] req,
        input logic [RATIO_W-1:0] lo,
        input logic [RATIO_W-1:0] hi
    );
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/pcap_edge_sync.sv
module pcap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pin,
    input  pcap_pkg::edge_sel_e  sel,
    output logic                 edge_o
);
    import pcap_pkg::*;

    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_n;
    logic              prev_q;
    logic              rise;
    logic              fall;

    // synchronizer chain, first stage samples the pin
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign sh_n[i] = pin;
        end else begin : g_next
            assign sh_n[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_n;
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign rise   = sh_q[STAGES-1] & ~prev_q;
    assign fall   = ~sh_q[STAGES-1] & prev_q;
    assign edge_o = (sel == EDGE_FALL) ? fall : rise;

    AST_SYNC_RISE_LAT: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(pin, STAGES)); // R10
    AST_SYNC_FALL_LAT: assert property (@(posedge clk) disable iff (rst)
        fall |-> !$past(pin, STAGES)); // R10
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R3

endmodule

// File: rtl/pcap_prescaler.sv
module pcap_prescaler #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               edge_i,
    output logic               tick
);
    logic [RATIO_W-1:0] cnt_q;

    assign tick = edge_i && !clr && (cnt_q == ratio - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (edge_i) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    AST_PS_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio); // R4
    AST_PS_STEP: assert property (@(posedge clk) disable iff (rst)
        edge_i && !clr && !tick |=> cnt_q == $past(cnt_q) + 1'b1); // R4
    AST_PS_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == '0); // R4
    AST_PS_IGNORE: assert property (@(posedge clk) disable iff (rst)
        !edge_i && !clr |=> $stable(cnt_q)); // R3
    AST_PS_CFG_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0); // R9

endmodule

// File: rtl/pcap_timebase.sv
module pcap_timebase #(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 tick,
    input  logic                 rd_clr,
    output logic [CNT_W-1:0]     res_o,
    output pcap_pkg::cap_flags_t flags_o
);
    import pcap_pkg::*;

    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] ctr_q;
    logic [CNT_W-1:0] res_q;
    cap_flags_t       flg_q;
    logic             fresh_q;
    logic             cap;

    assign cap = tick && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q   <= '0;
            res_q   <= '0;
            flg_q   <= '0;
            fresh_q <= 1'b1;
        end else if (clr) begin
            ctr_q   <= '0;
            fresh_q <= 1'b1;
            if (rd_clr) flg_q.valid <= 1'b0;
        end else if (cap) begin
            res_q         <= ctr_q;
            flg_q.valid   <= 1'b1;
            flg_q.ovf     <= (ctr_q == MAXV);
            flg_q.partial <= fresh_q;
            fresh_q       <= 1'b0;
            ctr_q         <= '0;
        end else begin
            if (ctr_q != MAXV) ctr_q <= ctr_q + 1'b1;
            if (rd_clr) flg_q.valid <= 1'b0;
        end
    end

    assign res_o   = res_q;
    assign flags_o = flg_q;

    AST_CTR_RESTART: assert property (@(posedge clk) disable iff (rst)
        cap |=> ctr_q == '0); // R5
    AST_CTR_INC: assert property (@(posedge clk) disable iff (rst)
        !cap && !clr && ctr_q != MAXV |=> ctr_q == $past(ctr_q) + 1'b1); // R5
    AST_CTR_SAT: assert property (@(posedge clk) disable iff (rst)
        !cap && !clr && ctr_q == MAXV |=> ctr_q == MAXV); // R6
    AST_CAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        cap |=> res_q == $past(ctr_q) && flg_q.valid); // R5
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(flg_q.ovf)); // R6
    AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
        rd_clr && !cap |=> !flg_q.valid); // R7
    AST_CFG_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> ctr_q == '0); // R9
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(res_q)); // R8

endmodule

// File: rtl/pcap_channel.sv
module pcap_channel #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int PS_MIN      = 25,
    parameter int PS_MAX      = 30,
    parameter int WORD_W      = CNT_W + pcap_pkg::FLAG_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          pin,
    input  logic                          cfg_hit,
    input  logic [pcap_pkg::RATIO_W-1:0]  cfg_ratio,
    input  logic                          cfg_fall,
    input  logic                          rd_clr,
    output logic [WORD_W-1:0]             word_o
);
    import pcap_pkg::*;

    localparam logic [RATIO_W-1:0] LO = RATIO_W'(PS_MIN);
    localparam logic [RATIO_W-1:0] HI = RATIO_W'(PS_MAX);

    logic [RATIO_W-1:0] ratio_q;
    edge_sel_e          sel_q;
    logic               edge_sel;
    logic               tick;
    logic [CNT_W-1:0]   res;
    cap_flags_t         flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= LO;
            sel_q   <= EDGE_RISE;
        end else if (cfg_hit) begin
            ratio_q <= clamp_ratio(cfg_ratio, LO, HI);
            sel_q   <= edge_sel_e'(cfg_fall);
        end
    end

    pcap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin    (pin),
        .sel    (sel_q),
        .edge_o (edge_sel)
    );

    pcap_prescaler #(.RATIO_W(RATIO_W)) u_ps (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_hit),
        .ratio  (ratio_q),
        .edge_i (edge_sel),
        .tick   (tick)
    );

    pcap_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .clr     (cfg_hit),
        .tick    (tick),
        .rd_clr  (rd_clr),
        .res_o   (res),
        .flags_o (flags)
    );

    assign word_o = {flags, res};

    AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (rst)
        ratio_q >= LO && ratio_q <= HI); // R4

endmodule

// File: rtl/period_capture_top.sv
module period_capture_top #(
    parameter int NCH         = 4,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int PS_MIN      = 25,
    parameter int PS_MAX      = 30,
    parameter int CH_W        = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int WORD_W      = CNT_W + pcap_pkg::FLAG_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NCH-1:0]                pulse_in,
    input  logic                          cfg_wr,
    input  logic [CH_W-1:0]               cfg_ch,
    input  logic [pcap_pkg::RATIO_W-1:0]  cfg_ratio,
    input  logic                          cfg_fall,
    input  logic                          rd_en,
    input  logic [CH_W-1:0]               rd_ch,
    output logic [WORD_W-1:0]             rd_data,
    output logic                          rd_ack
);
    import pcap_pkg::*;

    logic [WORD_W-1:0] words [NCH];
    logic [WORD_W-1:0] sel_word;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic cfg_hit;
        logic rd_clr;

        assign cfg_hit = cfg_wr && (int'(cfg_ch) == i);
        assign rd_clr  = rd_en && (int'(rd_ch) == i);

        pcap_channel #(
            .CNT_W       (CNT_W),
            .SYNC_STAGES (SYNC_STAGES),
            .PS_MIN      (PS_MIN),
            .PS_MAX      (PS_MAX),
            .WORD_W      (WORD_W)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .pin       (pulse_in[i]),
            .cfg_hit   (cfg_hit),
            .cfg_ratio (cfg_ratio),
            .cfg_fall  (cfg_fall),
            .rd_clr    (rd_clr),
            .word_o    (words[i])
        );
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(rd_ch) == i) sel_word = words[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_ack  <= 1'b0;
        end else begin
            rd_ack <= rd_en;
            if (rd_en) rd_data <= sel_word;
        end
    end

    AST_RD_ACK: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_ack); // R8
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_ack && $stable(rd_data)); // R8

endmodule

// File: tb/sim_period_capture_top.sv
module sim_period_capture_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int CH_W       = 2;
    localparam int CNT_W      = 12;
    localparam int WORD_W     = CNT_W + 3;
    localparam int MAXV       = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    pulse_in = '0;
    logic              cfg_wr = 1'b0;
    logic [CH_W-1:0]   cfg_ch = '0;
    logic [4:0]        cfg_ratio = '0;
    logic              cfg_fall = 1'b0;
    logic              rd_en = 1'b0;
    logic [CH_W-1:0]   rd_ch = '0;
    logic [WORD_W-1:0] rd_data;
    logic              rd_ack;

    period_capture_top #(.NCH(NCH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in),
        .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_ratio(cfg_ratio), .cfg_fall(cfg_fall),
        .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data), .rd_ack(rd_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    int ncyc = 0;

    logic [NCH-1:0] lvl = '0;
    logic [NCH-1:0] plvl = '0;
    bit act [NCH];
    int rem [NCH];
    int wlo [NCH];
    int whi [NCH];

    int m_cnt [NCH];
    int m_ratio [NCH];
    int m_last [NCH];
    bit m_fall [NCH];
    bit m_fresh [NCH];
    bit m_any [NCH];
    bit e_valid [NCH];
    bit e_ovf [NCH];
    bit e_part [NCH];
    int e_val [NCH];

    function automatic int bclamp(int r);
        if (r < 25) return 25;
        if (r > 30) return 30;
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, longint actv, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actv, expv);
        end
    endtask

    // model of one selected transition on channel c at bench cycle ncyc
    task automatic model_edge(int c);
        if (m_cnt[c] + 1 == m_ratio[c]) begin
            m_cnt[c] = 0;
            if (m_fresh[c]) begin
                e_part[c] = 1;
            end else begin
                int d = ncyc - m_last[c] - 1;
                e_part[c] = 0;
                e_val[c]  = (d > MAXV) ? MAXV : d;
                e_ovf[c]  = (d >= MAXV);
            end
            m_last[c]  = ncyc;
            m_fresh[c] = 0;
            m_any[c]   = 1;
            e_valid[c] = 1;
        end else begin
            m_cnt[c]++;
        end
    endtask

    task automatic step();
        @(negedge clk);
        ncyc++;
        for (int c = 0; c < NCH; c++) begin
            if (act[c]) begin
                if (rem[c] == 0) begin
                    lvl[c] = ~lvl[c];
                    rem[c] = int'($urandom_range(whi[c], wlo[c])) - 1;
                end else begin
                    rem[c]--;
                end
            end
            if (lvl[c] != plvl[c]) begin
                if (m_fall[c] ? (lvl[c] == 1'b0) : (lvl[c] == 1'b1)) model_edge(c);
            end
            plvl[c] = lvl[c];
        end
        pulse_in = lvl;
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic cfg(int c, int ratio, bit fall);
        cfg_wr = 1; cfg_ch = CH_W'(c); cfg_ratio = 5'(ratio); cfg_fall = fall;
        step();
        cfg_wr = 0;
        m_cnt[c] = 0; m_ratio[c] = bclamp(ratio); m_fall[c] = fall; m_fresh[c] = 1;
    endtask

    task automatic read_check(int c);
        logic [WORD_W-1:0] w;
        rd_en = 1; rd_ch = CH_W'(c);
        step();
        rd_en = 0;
        w = rd_data;
        chk(rd_ack == 1'b1, "R8", "read ack", rd_ack, 1);
        if (!m_any[c]) begin
            chk(w == '0, "R1", $sformatf("ch%0d word before any capture", c), w, 0);
        end else begin
            chk(w[CNT_W+2] == e_valid[c], "R7", $sformatf("ch%0d valid", c), w[CNT_W+2], e_valid[c]);
            chk(w[CNT_W] == e_part[c], "R9", $sformatf("ch%0d partial", c), w[CNT_W], e_part[c]);
            if (!e_part[c]) begin
                chk(int'(w[CNT_W-1:0]) == e_val[c], "R5",
                    $sformatf("ch%0d count (R2 R3 R4)", c), w[CNT_W-1:0], e_val[c]);
                chk(w[CNT_W+1] == e_ovf[c], "R6", $sformatf("ch%0d overflow", c), w[CNT_W+1], e_ovf[c]);
            end
        end
        e_valid[c] = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        for (int c = 0; c < NCH; c++) begin
            act[c] = 0; rem[c] = 0; wlo[c] = 1; whi[c] = 1;
            m_cnt[c] = 0; m_ratio[c] = 25; m_last[c] = 0; m_fall[c] = 0;
            m_fresh[c] = 1; m_any[c] = 0; e_valid[c] = 0; e_ovf[c] = 0;
            e_part[c] = 0; e_val[c] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 0;
        quiet(3);

        // R1: every channel reads as zero after reset
        for (int c = 0; c < NCH; c++) read_check(c);

        // R10 / R7: directed latency and read-coincident capture on channel 1
        cfg(1, 25, 1'b0);
        quiet(4);
        for (int n = 0; n < 25; n++) begin
            lvl[1] = 1; step(); step();
            lvl[1] = 0; step(); step();
        end
        quiet(6);
        read_check(1);
        for (int n = 0; n < 24; n++) begin
            lvl[1] = 1; step(); step();
            lvl[1] = 0; step(); step();
        end
        quiet(6);
        lvl[1] = 1;
        step();              // pin changes before edge E0
        step();
        step();
        rd_en = 1; rd_ch = 2'd1;
        step();              // read sampled at E2, same edge as the capture
        rd_en = 0;
        chk(rd_data[CNT_W+2] == 1'b0, "R10", "word before capture edge valid", rd_data[CNT_W+2], 0);
        chk(rd_data[CNT_W] == 1'b1, "R10", "word before capture edge partial", rd_data[CNT_W], 1);
        rd_en = 1; rd_ch = 2'd1;
        step();              // read sampled at E3
        rd_en = 0;
        chk(rd_data[CNT_W+2] == 1'b1, "R7", "capture beats coincident read", rd_data[CNT_W+2], 1);
        chk(rd_data[CNT_W] == 1'b0, "R10", "new word partial", rd_data[CNT_W], 0);
        chk(int'(rd_data[CNT_W-1:0]) == e_val[1], "R10", "new word count",
            rd_data[CNT_W-1:0], e_val[1]);
        e_valid[1] = 0;
        lvl[1] = 0;
        quiet(6);
        read_check(1);       // R7: valid now clear, data unchanged

        // R6: saturation on channel 0, then recovery
        cfg(0, 25, 1'b0);
        quiet(4);
        act[0] = 1; wlo[0] = 100; whi[0] = 100;
        quiet(16000);
        act[0] = 0;
        quiet(6);
        read_check(0);
        chk(e_ovf[0] == 1'b1, "R6", "scenario reached saturation", e_ovf[0], 1);
        act[0] = 1; wlo[0] = 2; whi[0] = 2;
        quiet(700);
        act[0] = 0;
        quiet(6);
        read_check(0);

        // random bursts: R2 R3 R4 R5 R9 with clamped and edge-selected reconfiguration
        for (int b = 0; b < 12; b++) begin
            if (b % 3 == 0) begin
                int rc = int'($urandom_range(NCH - 1, 0));
                int rr = int'($urandom_range(31, 18));
                cfg(rc, rr, 1'($urandom_range(1, 0)));
                quiet(4);
            end
            for (int c = 0; c < NCH; c++) begin
                act[c] = ($urandom_range(3, 0) != 0);
                wlo[c] = int'($urandom_range(3, 1));
                whi[c] = wlo[c] + int'($urandom_range(5, 0));
            end
            quiet(1200);
            for (int c = 0; c < NCH; c++) act[c] = 0;
            quiet(6);
            for (int c = 0; c < NCH; c++) read_check(c);
            read_check(int'($urandom_range(NCH - 1, 0)));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule